// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block steers control flow in a small 8-bit processor. It holds a 14-bit program counter and a private eight-entry stack of return addresses. Each cycle the decoder presents a command: advance sequentially, jump, call, return or restart. Jump, call and return may be gated by a 3-bit condition that tests one of four status flags for true or for false. A restart is a one-byte call to a fixed vector at eight times its 3-bit index.

Jump and call targets arrive as two operand bytes, the low address byte first. Only the low six bits of the high byte reach the counter. When no transfer happens, the counter advances by the current instruction length. A one-cycle `taken_o` pulse marks every transfer that is actually carried out. A sticky flag records a stack overflow.

All state changes on the rising clock edge. `pc_o`, `taken_o` and `ovf_o` reflect a command in the cycle after it was presented.

Top module: `flow_ctrl`

## Requirements
- R1: After reset `pc_o` is 0, `taken_o` is 0 and `ovf_o` is 0. The asynchronous reset is released through a two-stage synchronizer.
- R2: Command code 0 (advance), and the unused codes 5 to 7, add `ilen_i` (0 to 3) to the counter. A length of 0 holds the counter.
- R3: With `cond_en_i`=1, the condition `cc_i` is met when the flag selected by `cc_i[1:0]` equals `cc_i[2]`. The selection is 0 carry, 1 zero, 2 sign, 3 parity. `par_even_i`=1 means even parity, so code 3 tests for odd and code 7 tests for even.
- R4: A jump (code 1) whose condition is met loads `{tgt_hi_i[5:0], tgt_lo_i}`, with the low operand byte forming bits 7..0.
- R5: With `cond_en_i`=0, jump, call and return act whatever the flags are.
- R6: A call (code 2) whose condition is met pushes `pc_o + ilen_i` and loads the target. A call whose condition fails leaves the stack untouched and advances by `ilen_i`.
- R7: A return (code 3) whose condition is met loads the most recently pushed address and pops it. A return whose condition fails leaves the stack untouched and advances by `ilen_i`.
- R8: A restart (code 4) always pushes `pc_o + ilen_i` and loads `rst_idx_i` times 8.
- R9: `taken_o` is high for exactly the cycle after a performed jump, call, return or restart, and low otherwise.
- R10: The stack returns addresses in last-in-first-out order. A ninth live push wraps round, overwrites the oldest entry and sets `ovf_o`. `ovf_o` then stays set until reset.
- R11: A return on an empty stack wraps the pointer circularly and loads the entry in the slot below the pointer. It leaves `ovf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command: 0 advance, 1 jump, 2 call, 3 return, 4 restart |
| cond_en_i | input | 1 | 1 gates jump/call/return by `cc_i` |
| cc_i | input | 3 | Condition code: bit 2 polarity, bits 1..0 flag select |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| sign_i | input | 1 | Sign flag |
| par_even_i | input | 1 | Parity flag, 1 = even |
| ilen_i | input | 2 | Length of the current instruction (0 holds) |
| tgt_lo_i | input | 8 | First operand byte, target bits 7..0 |
| tgt_hi_i | input | 6 | Low bits of the second operand byte, target bits 13..8 |
| rst_idx_i | input | 3 | Restart vector index |
| pc_o | output | 14 | Program counter |
| taken_o | output | 1 | Transfer performed in the previous cycle |
| ovf_o | output | 1 | Sticky stack overflow |

## Verification
The bench sweeps all eight condition codes against all sixteen flag patterns for conditional jumps. A design that swapped polarity or flag select, or read parity the wrong way round, would load the target when it should advance, and `taken_o` would disagree. Calls and returns whose conditions fail are followed by returns that expose any stray push or pop. All eight restart vectors are checked for the N×8 address and a correct return address. The stack is driven past full, which must raise the sticky flag and lose only the oldest entry. It is also driven past empty, which must wrap to a known slot without raising the flag; a saturating pointer would return the wrong address in either case.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [2:0] {
    CMD_NEXT = 3'd0,
    CMD_JUMP = 3'd1,
    CMD_CALL = 3'd2,
    CMD_RET  = 3'd3,
    CMD_RST  = 3'd4
  } cmd_e;
endpackage

// File: rtl/flow_rst_sync.sv
module flow_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/flow_cond.sv
module flow_cond #(
  parameter int NFLAGS = 4
) (
  input  logic [$clog2(NFLAGS):0] cc_i,
  input  logic [NFLAGS-1:0]       flags_i,
  output logic                    hit_o
);
  localparam int SEL_W = $clog2(NFLAGS);

  logic [SEL_W-1:0] sel;
  logic             polarity;
  logic             flag_val;

  assign sel      = cc_i[SEL_W-1:0];
  assign polarity = cc_i[SEL_W];

  always_comb begin
    flag_val = 1'b0;
    for (int i = 0; i < NFLAGS; i++) begin
      if (sel == SEL_W'(i)) flag_val = flags_i[i];
    end
  end

  assign hit_o = (flag_val == polarity);
endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o,
  output logic         ovf_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FULL = (PTR_W+1)'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q, sp_n, sp_dec;
  logic [PTR_W:0]   cnt_q, cnt_n;
  logic             ovf_q, ovf_n;

  assign sp_dec = sp_q - 1'b1;
  assign top_o  = mem_q[sp_dec];
  assign ovf_o  = ovf_q;

  always_comb begin
    sp_n  = sp_q;
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    if (push_i) begin
      sp_n = sp_q + 1'b1;
      if (cnt_q == FULL) ovf_n = 1'b1;
      else               cnt_n = cnt_q + 1'b1;
    end else if (pop_i) begin
      sp_n = sp_dec;
      if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[sp_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i || pop_i) begin
        sp_q  <= sp_n;
        cnt_q <= cnt_n;
      end
      ovf_q <= ovf_n;
    end
  end

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R10
  AST_POP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !ovf_q) |=> !ovf_q); // R11
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
#(
  parameter int PC_W  = 14,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cmd_i,
  input  logic            cond_en_i,
  input  logic [2:0]      cc_i,
  input  logic            carry_i,
  input  logic            zero_i,
  input  logic            sign_i,
  input  logic            par_even_i,
  input  logic [1:0]      ilen_i,
  input  logic [7:0]      tgt_lo_i,
  input  logic [PC_W-9:0] tgt_hi_i,
  input  logic [2:0]      rst_idx_i,
  output logic [PC_W-1:0] pc_o,
  output logic            taken_o,
  output logic            ovf_o
);
  localparam int VEC_SHIFT = 3;

  logic            rst_sync_n;
  logic [PC_W-1:0] pc_q, pc_n, pc_seq, target, rst_vec, stk_top;
  logic            taken_q, take;
  logic            hit, cond_ok;
  logic            push, pop, pc_en;
  cmd_e            cmd;

  flow_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flow_cond #(.NFLAGS(4)) u_cond (
    .cc_i    (cc_i),
    .flags_i ({par_even_i, sign_i, zero_i, carry_i}),
    .hit_o   (hit)
  );

  flow_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (pc_seq),
    .top_o   (stk_top),
    .ovf_o   (ovf_o)
  );

  assign cmd     = cmd_e'(cmd_i);
  assign cond_ok = !cond_en_i || hit;
  assign pc_seq  = pc_q + PC_W'(ilen_i);
  assign target  = {tgt_hi_i, tgt_lo_i};
  assign rst_vec = PC_W'(rst_idx_i) << VEC_SHIFT;

  always_comb begin
    pc_n = pc_seq;
    take = 1'b0;
    push = 1'b0;
    pop  = 1'b0;
    unique case (cmd)
      CMD_JUMP: if (cond_ok) begin
        pc_n = target;
        take = 1'b1;
      end
      CMD_CALL: if (cond_ok) begin
        pc_n = target;
        take = 1'b1;
        push = 1'b1;
      end
      CMD_RET: if (cond_ok) begin
        pc_n = stk_top;
        take = 1'b1;
        pop  = 1'b1;
      end
      CMD_RST: begin
        pc_n = rst_vec;
        take = 1'b1;
        push = 1'b1;
      end
      default: ;
    endcase
  end

  assign pc_en = take || (ilen_i != 2'd0);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_n;
      taken_q <= take;
    end
  end

  assign pc_o    = pc_q;
  assign taken_o = taken_q;

  AST_HOLD_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 3'd0 && ilen_i == 2'd0) |=> $stable(pc_q)); // R2
  AST_ADVANCE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 3'd0) |=> !taken_o); // R9
  AST_RESTART_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 3'd4) |=> (taken_o && pc_o[2:0] == 3'd0)); // R8
  AST_UNCOND_JUMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 3'd1 && !cond_en_i) |=> (taken_o && pc_o[7:0] == $past(tgt_lo_i))); // R5
  AST_RET_LOADS_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 3'd3 && !cond_en_i) |=> pc_o == $past(stk_top)); // R7
endmodule

// File: tb/sim_flow_ctrl.sv
`timescale 1ns/1ps
module sim_flow_ctrl;
  localparam real HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_i, cc_i, rst_idx_i;
  logic        cond_en_i, carry_i, zero_i, sign_i, par_even_i;
  logic [1:0]  ilen_i;
  logic [7:0]  tgt_lo_i;
  logic [5:0]  tgt_hi_i;
  logic [13:0] pc_o;
  logic        taken_o, ovf_o;

  int errors = 0;
  int checks = 0;

  logic [13:0] m_pc;
  logic [13:0] m_stk [8];
  int          m_sp, m_cnt;
  logic        m_ovf, m_tk;

  always #(HALF) clk = ~clk;

  flow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .cond_en_i(cond_en_i), .cc_i(cc_i),
    .carry_i(carry_i), .zero_i(zero_i), .sign_i(sign_i), .par_even_i(par_even_i),
    .ilen_i(ilen_i), .tgt_lo_i(tgt_lo_i), .tgt_hi_i(tgt_hi_i), .rst_idx_i(rst_idx_i),
    .pc_o(pc_o), .taken_o(taken_o), .ovf_o(ovf_o)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_push(logic [13:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
    if (m_cnt == 8) m_ovf = 1'b1;
    else            m_cnt++;
  endtask

  task automatic m_pop(output logic [13:0] v);
    m_sp = (m_sp + 7) % 8;
    v = m_stk[m_sp];
    if (m_cnt > 0) m_cnt--;
  endtask

  task automatic step(string tag, logic [2:0] c, logic ce, logic [2:0] cc,
                      logic [3:0] fl, logic [7:0] lo, logic [5:0] hi,
                      logic [2:0] n, logic [1:0] il);
    logic        ok;
    logic [13:0] seq, tgt, popv;
    @(negedge clk);
    cmd_i = c; cond_en_i = ce; cc_i = cc;
    {par_even_i, sign_i, zero_i, carry_i} = fl;
    tgt_lo_i = lo; tgt_hi_i = hi; rst_idx_i = n; ilen_i = il;
    ok  = !ce || (fl[cc[1:0]] == cc[2]);
    seq = m_pc + 14'(il);
    tgt = 14'(hi) * 14'd256 + 14'(lo);
    m_tk = 1'b0;
    case (c)
      3'd1: if (ok) begin m_tk = 1'b1; seq = tgt; end
      3'd2: if (ok) begin m_tk = 1'b1; m_push(seq); seq = tgt; end
      3'd3: if (ok) begin m_tk = 1'b1; m_pop(popv); seq = popv; end
      3'd4: begin m_tk = 1'b1; m_push(seq); seq = 14'(n) * 14'd8; end
      default: ;
    endcase
    m_pc = seq;
    @(posedge clk);
    #2;
    check(tag, "pc", 32'(pc_o), 32'(m_pc));
    check(tag, "taken", 32'(taken_o), 32'(m_tk));
    check(tag, "ovf", 32'(ovf_o), 32'(m_ovf));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_i = 3'd0; ilen_i = 2'd0; cond_en_i = 1'b0; cc_i = '0;
    {par_even_i, sign_i, zero_i, carry_i} = 4'h0;
    tgt_lo_i = '0; tgt_hi_i = '0; rst_idx_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_pc = '0; m_sp = 0; m_cnt = 0; m_ovf = 1'b0; m_tk = 1'b0;
    check("R1", "reset pc", 32'(pc_o), 32'd0);
    check("R1", "reset taken", 32'(taken_o), 32'd0);
    check("R1", "reset ovf", 32'(ovf_o), 32'd0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    do_reset();

    // R2: sequential advance and hold; unused codes behave as advance
    for (int l = 0; l < 4; l++) step("R2", 3'd0, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'd0, 2'(l));
    step("R2", 3'd0, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'd0, 2'd0);
    for (int c = 5; c < 8; c++) step("R2", 3'(c), 1'b1, 3'd0, 4'hF, 8'h0, 6'h0, 3'd0, 2'd2);

    // R3, R4, R9: full condition sweep on conditional jumps
    for (int cc = 0; cc < 8; cc++)
      for (int fl = 0; fl < 16; fl++) begin
        step("R3", 3'd1, 1'b1, 3'(cc), 4'(fl), 8'(cc * 16 + fl + 3), 6'(cc * 7 + fl), 3'd0, 2'd3);
      end
    step("R4", 3'd1, 1'b0, 3'd0, 4'h0, 8'hA5, 6'h3C, 3'd0, 2'd3);

    // R5: unconditional jump with every flag pattern against a failing code
    for (int fl = 0; fl < 16; fl++) step("R5", 3'd1, 1'b0, 3'd4, 4'(fl), 8'(fl), 6'h15, 3'd0, 2'd3);

    // R6, R7: failing call/return do not touch the stack
    step("R6", 3'd2, 1'b1, 3'd4, 4'h0, 8'h10, 6'h01, 3'd0, 2'd3);
    step("R6", 3'd2, 1'b1, 3'd5, 4'h2, 8'h40, 6'h02, 3'd0, 2'd3);
    step("R7", 3'd3, 1'b1, 3'd1, 4'h2, 8'h00, 6'h00, 3'd0, 2'd1);
    step("R6", 3'd2, 1'b0, 3'd0, 4'h0, 8'h80, 6'h03, 3'd0, 2'd3);
    step("R7", 3'd3, 1'b1, 3'd6, 4'h0, 8'h00, 6'h00, 3'd0, 2'd1);
    step("R7", 3'd3, 1'b1, 3'd2, 4'h0, 8'h00, 6'h00, 3'd0, 2'd1);
    step("R7", 3'd3, 1'b1, 3'd7, 4'h8, 8'h00, 6'h00, 3'd0, 2'd1);

    // R8: every restart vector, each followed by a return
    for (int n = 0; n < 8; n++) begin
      step("R8", 3'd4, 1'b1, 3'd0, 4'h1, 8'h0, 6'h0, 3'(n), 2'd1);
      step("R8", 3'd3, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'd0, 2'd1);
    end

    // R10: overflow by nine nested calls, then drain LIFO
    do_reset();
    for (int k = 0; k < 9; k++) step("R10", 3'd2, 1'b0, 3'd0, 4'h0, 8'(k * 9 + 1), 6'(k + 1), 3'd0, 2'(k % 3 + 1));
    for (int k = 0; k < 9; k++) step("R10", 3'd3, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'd0, 2'd1);
    step("R10", 3'd0, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'd0, 2'd1);

    // R11: underflow wraps without raising the flag
    do_reset();
    for (int k = 0; k < 8; k++) step("R11", 3'd4, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'(k), 2'd1);
    for (int k = 0; k < 10; k++) step("R11", 3'd3, 1'b0, 3'd0, 4'h0, 8'h0, 6'h0, 3'd0, 2'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule